// File: doc/BRIEF.md
# Two-Register Nibble Execute Unit

This block is the execute stage of a very small load/store processor. It holds two 4-bit working registers, A and B. A sixteen-function ALU reads both registers all the time. A sequencer outside the block drives every control input on every clock. It chooses the operation, chooses whether a register takes an external immediate or the ALU result, and chooses which registers capture that value.

There is one write-data mux, shared by both registers. A register changes only on a rising clock edge while its own load enable is high. The ALU never sees the immediate. To operate on a value, the sequencer first loads it into A or B, then issues the operation in a later cycle.

The block reports the sign bit of the ALU result combinationally, so a decoder can branch on it in the same cycle. The register width is a parameter with a default of 4. The reset input is asynchronous and active low. Inside the block it is released synchronously after two clock edges.

Top module: `nib_exec_unit`

## Requirements
- R1: While `rst_n` is low, both registers read 0, and they are cleared as soon as `rst_n` falls, without waiting for a clock edge.
- R2: With `src_sel`=1, a register whose load enable is high takes `imm_x` at the next rising edge.
- R3: With `src_sel`=0, a register whose load enable is high takes the current ALU result at the next rising edge.
- R4: A register whose load enable is low keeps its value, whatever the other inputs are.
- R5: When `ld_a` and `ld_b` are both high, both registers take the same mux value.
- R6: Logic opcodes: 0x0 gives ~A, 0x1 gives ~B, 0x2 gives A&B, 0x3 gives A|B, 0x4 gives ~(A&B), 0x5 gives ~(A|B), 0x6 gives A^B, 0x7 gives ~(A^B).
- R7: Opcode 0x8 gives A and opcode 0x9 gives B, unchanged.
- R8: Opcode 0xA gives A+1, 0xB gives B+1, 0xC gives A-1 and 0xD gives B-1, all modulo 16.
- R9: Opcode 0xE gives A+B with `cin` ignored. Opcode 0xF gives A+B+`cin`. Both are taken modulo 16.
- R10: `neg` equals bit 3 of the ALU result for the current register contents, opcode and `cin`, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imm_x | input | 4 | External immediate value |
| src_sel | input | 1 | Write source: 1 selects the immediate, 0 selects the ALU result |
| ld_a | input | 1 | Load enable for register A |
| ld_b | input | 1 | Load enable for register B |
| opc | input | 4 | ALU operation code |
| cin | input | 1 | Carry input, used only by opcode 0xF |
| a_out | output | 4 | Contents of register A |
| b_out | output | 4 | Contents of register B |
| neg | output | 1 | Bit 3 of the ALU result |

## Verification
`neg` is combinational from the registers, the opcode and `cin`. It is due in the same cycle as its inputs. The bench drives the inputs on the falling edge and compares `neg` one time unit later, before the next rising edge.

A register write appears on `a_out` or `b_out` one rising edge after the load cycle. The bench compares both registers at the following falling edge. At that point the behavioural model has already applied the write.

A reset that falls in mid-run is checked one time unit after it falls, with no clock edge in between. This proves the clear is asynchronous.

// File: rtl/nib_exec_pkg.sv
package nib_exec_pkg;

  // ALU operation codes; the numeric values are the external opcode map
  typedef enum logic [3:0] {
    OP_NOT_A  = 4'h0,
    OP_NOT_B  = 4'h1,
    OP_AND    = 4'h2,
    OP_OR     = 4'h3,
    OP_NAND   = 4'h4,
    OP_NOR    = 4'h5,
    OP_XOR    = 4'h6,
    OP_XNOR   = 4'h7,
    OP_PASS_A = 4'h8,
    OP_PASS_B = 4'h9,
    OP_INC_A  = 4'hA,
    OP_INC_B  = 4'hB,
    OP_DEC_A  = 4'hC,
    OP_DEC_B  = 4'hD,
    OP_ADD    = 4'hE,
    OP_ADD_C  = 4'hF
  } alu_op_e;

  localparam int unsigned N_REGS = 2;
  localparam int unsigned IDX_A  = 0;
  localparam int unsigned IDX_B  = 1;

endpackage

// File: rtl/nib_alu_core.sv
module nib_alu_core #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0]         opa,
  input  logic [W-1:0]         opb,
  input  nib_exec_pkg::alu_op_e op,
  input  logic                 cin,
  output logic [W-1:0]         res,
  output logic                 msb
);
  import nib_exec_pkg::*;

  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONES = '1;

  // one shared adder: operands and carry chosen per opcode
  logic [W-1:0] add_l;
  logic [W-1:0] add_r;
  logic         add_c;
  logic [W-1:0] add_sum;
  logic         is_arith;

  always_comb begin
    add_l    = opa;
    add_r    = ZERO;
    add_c    = 1'b0;
    is_arith = 1'b1;
    unique case (op)
      OP_INC_A: begin add_l = opa; add_r = ZERO; add_c = 1'b1; end
      OP_INC_B: begin add_l = opb; add_r = ZERO; add_c = 1'b1; end
      OP_DEC_A: begin add_l = opa; add_r = ONES; add_c = 1'b0; end
      OP_DEC_B: begin add_l = opb; add_r = ONES; add_c = 1'b0; end
      OP_ADD:   begin add_l = opa; add_r = opb;  add_c = 1'b0; end
      OP_ADD_C: begin add_l = opa; add_r = opb;  add_c = cin;  end
      default:  is_arith = 1'b0;
    endcase
  end

  assign add_sum = add_l + add_r + {{(W-1){1'b0}}, add_c};

  logic [W-1:0] logic_res;

  always_comb begin
    unique case (op)
      OP_NOT_A:  logic_res = ~opa;
      OP_NOT_B:  logic_res = ~opb;
      OP_AND:    logic_res = opa & opb;
      OP_OR:     logic_res = opa | opb;
      OP_NAND:   logic_res = ~(opa & opb);
      OP_NOR:    logic_res = ~(opa | opb);
      OP_XOR:    logic_res = opa ^ opb;
      OP_XNOR:   logic_res = ~(opa ^ opb);
      OP_PASS_A: logic_res = opa;
      OP_PASS_B: logic_res = opb;
      default:   logic_res = ZERO;
    endcase
  end

  assign res = is_arith ? add_sum : logic_res;
  assign msb = res[W-1];

  // R8: an increment or decrement result is never equal to its source operand
  always_comb begin
    if (op == OP_INC_A || op == OP_DEC_A)
      a_incdec_moves_r8: assert (res != opa);
  end

endmodule

// File: rtl/nib_reg_slot.sv
module nib_reg_slot #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (ld) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(q));

  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (q == $past(d)));

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (q == '0));

endmodule

// File: rtl/nib_exec_unit.sv
module nib_exec_unit #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] imm_x,
  input  logic         src_sel,
  input  logic         ld_a,
  input  logic         ld_b,
  input  logic [3:0]   opc,
  input  logic         cin,
  output logic [W-1:0] a_out,
  output logic [W-1:0] b_out,
  output logic         neg
);
  import nib_exec_pkg::*;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_n_core;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end

  assign rst_n_core = rst_pipe[1];

  logic [W-1:0]      alu_res;
  logic              alu_msb;
  logic [W-1:0]      wr_data;
  logic [N_REGS-1:0] ld_vec;
  logic [W-1:0]      q_arr [N_REGS];

  assign ld_vec[IDX_A] = ld_a;
  assign ld_vec[IDX_B] = ld_b;

  assign wr_data = src_sel ? imm_x : alu_res;

  for (genvar g = 0; g < N_REGS; g++) begin : g_slot
    nib_reg_slot #(.W(W)) u_slot (
      .clk   (clk),
      .rst_n (rst_n_core),
      .ld    (ld_vec[g]),
      .d     (wr_data),
      .q     (q_arr[g])
    );
  end

  nib_alu_core #(.W(W)) u_alu (
    .opa (q_arr[IDX_A]),
    .opb (q_arr[IDX_B]),
    .op  (alu_op_e'(opc)),
    .cin (cin),
    .res (alu_res),
    .msb (alu_msb)
  );

  assign a_out = q_arr[IDX_A];
  assign b_out = q_arr[IDX_B];
  assign neg   = alu_msb;

  p_imm_load_r2: assert property (@(posedge clk) disable iff (!rst_n_core)
    (ld_a && src_sel) |=> (a_out == $past(imm_x)));

  p_both_same_r5: assert property (@(posedge clk) disable iff (!rst_n_core)
    (ld_a && ld_b) |=> (a_out == b_out));

  p_neg_pass_r10: assert property (@(posedge clk) disable iff (!rst_n_core)
    (opc == 4'h9) |-> (neg == b_out[W-1]));

  p_pass_load_r7: assert property (@(posedge clk) disable iff (!rst_n_core)
    (ld_b && !src_sel && opc == 4'h8) |=> (b_out == $past(a_out)));

endmodule

// File: tb/nib_exec_unit_tb.sv
module nib_exec_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] imm_x;
  logic       src_sel;
  logic       ld_a;
  logic       ld_b;
  logic [3:0] opc;
  logic       cin;
  logic [3:0] a_out;
  logic [3:0] b_out;
  logic       neg;

  always #10 clk = ~clk;

  nib_exec_unit #(.W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .imm_x(imm_x), .src_sel(src_sel),
    .ld_a(ld_a), .ld_b(ld_b), .opc(opc), .cin(cin),
    .a_out(a_out), .b_out(b_out), .neg(neg)
  );

  int    n_checks = 0;
  int    n_fails  = 0;
  int    m_a = 0;
  int    m_b = 0;
  string last_tag = "R1";

  function automatic int ref_alu(int a, int b, int op, int c);
    int r;
    case (op)
      0:  r = ~a;
      1:  r = ~b;
      2:  r = a & b;
      3:  r = a | b;
      4:  r = ~(a & b);
      5:  r = ~(a | b);
      6:  r = a ^ b;
      7:  r = ~(a ^ b);
      8:  r = a;
      9:  r = b;
      10: r = a + 1;
      11: r = b + 1;
      12: r = a - 1;
      13: r = b - 1;
      14: r = a + b;
      default: r = a + b + c;
    endcase
    return r & 15;
  endfunction

  function automatic string op_tag(int op);
    if (op < 8)  return "R6";
    if (op < 10) return "R7";
    if (op < 14) return "R8";
    return "R9";
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit sel, bit la, bit lb, int x, int op, bit c);
    int exp, d;
    @(negedge clk);
    check(last_tag, "a_out", int'(a_out), m_a);
    check(last_tag, "b_out", int'(b_out), m_b);
    src_sel = sel; ld_a = la; ld_b = lb; imm_x = 4'(x); opc = 4'(op); cin = c;
    #1;
    exp = ref_alu(m_a, m_b, op, int'(c));
    check({"R10/", op_tag(op)}, "neg", int'(neg), (exp >> 3) & 1);
    d = sel ? x : exp;
    if (la) m_a = d;
    if (lb) m_b = d;
    if (la && lb)      last_tag = "R5";
    else if (la || lb) last_tag = sel ? "R2" : "R3";
    else               last_tag = "R4";
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; imm_x = '0; src_sel = 0; ld_a = 0; ld_b = 0; opc = '0; cin = 0;
    #1;
    check("R1", "a_out reset", int'(a_out), 0);
    check("R1", "b_out reset", int'(b_out), 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // load operands, then sweep every opcode with both carries (R6..R10)
    step(1, 1, 0, 5, 8, 0);
    step(1, 0, 1, 3, 8, 0);
    for (int op = 0; op < 16; op++) begin
      step(0, 0, 0, 9, op, 0);
      step(0, 0, 0, 9, op, 1);
    end
    // write back ALU results (R3), including subtraction-style sequence
    step(0, 1, 0, 0, 14, 0);
    step(0, 0, 1, 0, 12, 0);
    // wraparound corners (R8, R9)
    step(1, 1, 1, 15, 8, 0);
    step(0, 1, 0, 0, 10, 0);
    step(0, 0, 1, 0, 13, 0);
    step(1, 1, 1, 15, 8, 0);
    step(0, 1, 0, 0, 15, 1);
    step(1, 0, 1, 0, 8, 0);
    step(0, 0, 1, 0, 13, 0);
    // both enables with the ALU result (R5)
    step(0, 1, 1, 0, 0, 0);
    // idle with inputs wiggling (R4)
    step(1, 0, 0, 10, 7, 1);
    step(0, 0, 0, 4, 15, 1);
    // random mix
    for (int i = 0; i < 600; i++) begin
      step(1'($urandom), 1'($urandom), 1'($urandom), int'($urandom_range(15)),
           int'($urandom_range(15)), 1'($urandom));
    end
    step(0, 0, 0, 0, 8, 0);

    // asynchronous clear in mid-run (R1)
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", "a_out async clear", int'(a_out), 0);
    check("R1", "b_out async clear", int'(b_out), 0);
    m_a = 0; m_b = 0; last_tag = "R1";
    ld_a = 0; ld_b = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    step(1, 0, 1, 6, 9, 0);
    step(0, 0, 0, 0, 9, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule